// File: doc/BRIEF.md
# 10/20-bit Video Lane Demultiplexer

This block sits on the parallel video input of a serial transmitter. It turns the incoming word bus into aligned luma/chroma pairs. The bus comes in one of two formats. In the wide format, luma and chroma arrive on separate 10-bit lanes on every clock. In the narrow format, chroma and luma words take turns on the upper lane and the clock runs at twice the wide-format rate.

In the narrow format, the block finds word phase by itself. It watches for the timing-reference preamble (all ones, zero, zero) and treats the next word as the luma half of a pair. After that it keeps alternating between chroma and luma. A mode select also offers two more settings. Pass-through sends raw lane contents out unaltered. The asynchronous-serial mode carries data on the upper lane only.

HD and SD operation differ only in clock frequency, so the block has no rate input. Every output is registered, with one clock of latency.

Top module: `vid_lane_demux`

## Requirements
- R1: While rst_n is low, pair_vld_o is low. pair_vld_o also stays low after the first clock edge that samples rst_n high.
- R2: With wide_sel=1 and mode_sel=00 (video), each edge sets luma_o to din[19:10], sets chroma_o to din[9:0] and raises pair_vld_o.
- R3: With mode_sel=01 (pass-through), there is no preamble tracking. With wide_sel=1, both lanes go out raw, as in R2. With wide_sel=0, luma_o takes din[19:10] and chroma_o is 0. In both cases pair_vld_o is high on every edge.
- R4: With mode_sel[1]=1 (asynchronous-serial, codes 10 and 11), luma_o takes din[19:10], chroma_o is 0 and pair_vld_o is high on every edge, whatever the width.
- R5: With wide_sel=0 and mode_sel=00, no pair is valid until alignment. Alignment happens when three consecutive upper words are 3FF, 000, 000. The word after them is output as luma, with the preceding upper word (000) as chroma.
- R6: Once aligned, upper words alternate chroma then luma. Each luma word yields a valid pair whose chroma is the word just before it. pair_vld_o is low after chroma words.
- R7: A preamble seen while already aligned resets the phase. The word after it is output as luma even when the running phase expected chroma.
- R8: In every narrow mode, din[9:0] has no effect on any output.
- R9: On an edge where wide_sel differs from its value at the previous edge, pair_vld_o goes low. Narrow video alignment and preamble history are discarded, so a complete new preamble is needed after the change.
- R10: Any edge outside narrow video mode discards alignment and preamble history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wide_sel | input | 1 | 1: separate luma/chroma lanes; 0: interleaved on upper lane |
| mode_sel | input | 2 | 00 video, 01 pass-through, 1x asynchronous-serial |
| din | input | 2*W | Upper lane [2W-1:W], lower lane [W-1:0] |
| pair_vld_o | output | 1 | Output pair valid |
| luma_o | output | W | Luma (or raw upper) word |
| chroma_o | output | W | Chroma (or raw lower) word |

## Verification
The bench uses the default word width W=10. At that width the preamble values 3FF and 000 can be written literally, so the vectors can place preambles at chosen phases: one at the expected phase, one against the running phase, and one made partly stale by a width change. Lower-lane contents in the narrow vectors include preamble-like values. This shows that pair contents come only from upper-lane history.

// File: rtl/vid_lane_demux.sv
module vid_lane_demux #(
  parameter int W = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wide_sel,
  input  logic [1:0]     mode_sel,
  input  logic [2*W-1:0] din,
  output logic           pair_vld_o,
  output logic [W-1:0]   luma_o,
  output logic [W-1:0]   chroma_o
);
  localparam logic [W-1:0] WORD_ONES = '1;
  localparam logic [W-1:0] WORD_ZERO = '0;
  localparam logic [1:0]   MODE_VID  = 2'b00;

  logic [W-1:0] lane_hi, lane_lo;
  logic [W-1:0] hist1, hist2, hist3;
  logic         wide_q, primed, aligned, luma_ph;
  logic         wchg, track, trs_hit, emit;

  assign lane_hi = din[2*W-1:W];
  assign lane_lo = din[W-1:0];
  assign wchg    = !primed || (wide_sel != wide_q);
  assign track   = (mode_sel == MODE_VID) && !wide_sel;
  assign trs_hit = track && hist3 == WORD_ONES && hist2 == WORD_ZERO && hist1 == WORD_ZERO;
  assign emit    = trs_hit || (aligned && luma_ph);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed  <= 1'b0;
      wide_q  <= 1'b0;
      aligned <= 1'b0;
      luma_ph <= 1'b0;
      hist1   <= '0;
      hist2   <= '0;
      hist3   <= '0;
    end else begin
      primed <= 1'b1;
      wide_q <= wide_sel;
      if (wchg || !track) begin
        aligned <= 1'b0;
        luma_ph <= 1'b0;
        hist1   <= '0;
        hist2   <= '0;
        hist3   <= '0;
      end else begin
        hist1 <= lane_hi;
        hist2 <= hist1;
        hist3 <= hist2;
        if (trs_hit) begin
          aligned <= 1'b1;
          luma_ph <= 1'b0;
        end else if (aligned) begin
          luma_ph <= !luma_ph;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_vld_o <= 1'b0;
      luma_o     <= '0;
      chroma_o   <= '0;
    end else if (wchg) begin
      pair_vld_o <= 1'b0;
    end else if (track) begin
      pair_vld_o <= emit;
      if (emit) begin
        luma_o   <= lane_hi;
        chroma_o <= hist1;
      end
    end else if (mode_sel[1] || !wide_sel) begin
      pair_vld_o <= 1'b1;
      luma_o     <= lane_hi;
      chroma_o   <= '0;
    end else begin
      pair_vld_o <= 1'b1;
      luma_o     <= lane_hi;
      chroma_o   <= lane_lo;
    end
  end
endmodule

module vid_lane_demux_chk #(
  parameter int W = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wide_sel,
  input logic [1:0]     mode_sel,
  input logic [2*W-1:0] din,
  input logic           pair_vld_o,
  input logic [W-1:0]   luma_o,
  input logic [W-1:0]   chroma_o
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> !pair_vld_o);

  // R9
  width_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && (wide_sel != $past(wide_sel)) |=> !pair_vld_o);

  // R2
  wide_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && wide_sel && $past(wide_sel) && !mode_sel[1]
    |=> pair_vld_o && luma_o == $past(din[2*W-1:W]) && chroma_o == $past(din[W-1:0]));

  // R4
  upper_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && mode_sel[1] && (wide_sel == $past(wide_sel))
    |=> pair_vld_o && chroma_o == '0 && luma_o == $past(din[2*W-1:W]));

  // R6
  pair_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_vld_o && $past(!wide_sel && mode_sel == 2'b00)
    |-> luma_o == $past(din[2*W-1:W]) && chroma_o == $past(din[2*W-1:W], 2));
endmodule

bind vid_lane_demux vid_lane_demux_chk #(.W(W)) u_chk (.*);

// File: tb/vid_lane_demux_test.sv
module vid_lane_demux_test;
  localparam int W  = 10;
  localparam int NV = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wide_sel = 1'b1;
  logic [1:0]    mode_sel = 2'b00;
  logic [2*W-1:0] din = '0;
  logic          pair_vld_o;
  logic [W-1:0]  luma_o, chroma_o;
  int            n_chk = 0;
  int            n_bad = 0;

  always #5 clk = ~clk;

  vid_lane_demux #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .wide_sel(wide_sel), .mode_sel(mode_sel),
    .din(din), .pair_vld_o(pair_vld_o), .luma_o(luma_o), .chroma_o(chroma_o));

  // {req, wide, mode, din_hi, din_lo, exp_vld, exp_luma, exp_chroma}
  localparam logic [47:0] VEC [NV] = '{
    {4'd1, 1'b1,2'd0, 10'h123,10'h045, 1'b0,10'h000,10'h000},  // R1 first edge
    {4'd2, 1'b1,2'd0, 10'h2AA,10'h155, 1'b1,10'h2AA,10'h155},  // R2
    {4'd2, 1'b1,2'd0, 10'h3FF,10'h000, 1'b1,10'h3FF,10'h000},  // R2
    {4'd9, 1'b0,2'd0, 10'h3FF,10'h3A5, 1'b0,10'h000,10'h000},  // R9 change edge
    {4'd9, 1'b0,2'd0, 10'h000,10'h1C7, 1'b0,10'h000,10'h000},  // R9
    {4'd9, 1'b0,2'd0, 10'h000,10'h2B2, 1'b0,10'h000,10'h000},  // R9
    {4'd9, 1'b0,2'd0, 10'h1AB,10'h0F0, 1'b0,10'h000,10'h000},  // R9 stale preamble
    {4'd5, 1'b0,2'd0, 10'h3FF,10'h3FF, 1'b0,10'h000,10'h000},  // R5
    {4'd5, 1'b0,2'd0, 10'h000,10'h155, 1'b0,10'h000,10'h000},  // R5
    {4'd5, 1'b0,2'd0, 10'h000,10'h2AA, 1'b0,10'h000,10'h000},  // R5
    {4'd5, 1'b0,2'd0, 10'h200,10'h3FF, 1'b1,10'h200,10'h000},  // R5 luma after preamble
    {4'd6, 1'b0,2'd0, 10'h040,10'h3FF, 1'b0,10'h000,10'h000},  // R6 chroma
    {4'd8, 1'b0,2'd0, 10'h111,10'h000, 1'b1,10'h111,10'h040},  // R8 R6
    {4'd6, 1'b0,2'd0, 10'h0C0,10'h155, 1'b0,10'h000,10'h000},  // R6
    {4'd8, 1'b0,2'd0, 10'h222,10'h2AA, 1'b1,10'h222,10'h0C0},  // R8 R6
    {4'd6, 1'b0,2'd0, 10'h050,10'h3FF, 1'b0,10'h000,10'h000},  // R6
    {4'd6, 1'b0,2'd0, 10'h3FF,10'h111, 1'b1,10'h3FF,10'h050},  // R6
    {4'd6, 1'b0,2'd0, 10'h000,10'h000, 1'b0,10'h000,10'h000},  // R6
    {4'd6, 1'b0,2'd0, 10'h000,10'h3FF, 1'b1,10'h000,10'h000},  // R6
    {4'd7, 1'b0,2'd0, 10'h274,10'h222, 1'b1,10'h274,10'h000},  // R7 forced luma
    {4'd7, 1'b0,2'd0, 10'h080,10'h1C7, 1'b0,10'h000,10'h000},  // R7
    {4'd7, 1'b0,2'd0, 10'h1F0,10'h3A5, 1'b1,10'h1F0,10'h080},  // R7
    {4'd3, 1'b0,2'd1, 10'h155,10'h3C3, 1'b1,10'h155,10'h000},  // R3 narrow raw
    {4'd3, 1'b0,2'd1, 10'h3FF,10'h0F0, 1'b1,10'h3FF,10'h000},  // R3
    {4'd9, 1'b1,2'd1, 10'h0AA,10'h355, 1'b0,10'h000,10'h000},  // R9
    {4'd3, 1'b1,2'd1, 10'h0AA,10'h355, 1'b1,10'h0AA,10'h355},  // R3 wide raw
    {4'd4, 1'b1,2'd2, 10'h1BC,10'h2DE, 1'b1,10'h1BC,10'h000},  // R4
    {4'd9, 1'b0,2'd2, 10'h1BC,10'h2DE, 1'b0,10'h000,10'h000},  // R9
    {4'd4, 1'b0,2'd3, 10'h0FE,10'h123, 1'b1,10'h0FE,10'h000},  // R4 code 11
    {4'd10,1'b0,2'd0, 10'h3FF,10'h000, 1'b0,10'h000,10'h000},  // R10
    {4'd10,1'b0,2'd0, 10'h000,10'h2AA, 1'b0,10'h000,10'h000},  // R10
    {4'd10,1'b0,2'd0, 10'h000,10'h155, 1'b0,10'h000,10'h000},  // R10
    {4'd10,1'b0,2'd0, 10'h3A0,10'h111, 1'b1,10'h3A0,10'h000},  // R10
    {4'd10,1'b0,2'd1, 10'h111,10'h000, 1'b1,10'h111,10'h000},  // R10 leave video
    {4'd10,1'b0,2'd0, 10'h045,10'h000, 1'b0,10'h000,10'h000},  // R10
    {4'd10,1'b0,2'd0, 10'h046,10'h000, 1'b0,10'h000,10'h000}   // R10 no stale phase
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [1:0] m, input logic [2*W-1:0] d);
    wide_sel = w;
    mode_sel = m;
    din      = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset vld", {31'd0, pair_vld_o}, 32'd0);
    check("R1 reset luma", {22'd0, luma_o}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][43], VEC[i][42:41], VEC[i][40:21]);
      check($sformatf("R%0d vec%0d vld", VEC[i][47:44], i), {31'd0, pair_vld_o}, {31'd0, VEC[i][20]});
      if (VEC[i][20]) begin
        check($sformatf("R%0d vec%0d luma", VEC[i][47:44], i), {22'd0, luma_o}, {22'd0, VEC[i][19:10]});
        check($sformatf("R%0d vec%0d chroma", VEC[i][47:44], i), {22'd0, chroma_o}, {22'd0, VEC[i][9:0]});
      end
    end

    // R1: reset mid-run after a valid wide pair
    step(1'b1, 2'd0, {10'h321, 10'h123});
    step(1'b1, 2'd0, {10'h321, 10'h123});
    check("R2 pre-reset vld", {31'd0, pair_vld_o}, 32'd1);
    rst_n = 1'b0;
    #1;
    check("R1 async clear", {31'd0, pair_vld_o}, 32'd0);
    step(1'b1, 2'd0, {10'h111, 10'h222});
    check("R1 held in reset", {31'd0, pair_vld_o}, 32'd0);
    rst_n = 1'b1;
    step(1'b1, 2'd0, {10'h133, 10'h244});
    check("R1 first edge after release", {31'd0, pair_vld_o}, 32'd0);
    step(1'b1, 2'd0, {10'h155, 10'h266});
    check("R2 after release vld", {31'd0, pair_vld_o}, 32'd1);
    check("R2 after release luma", {22'd0, luma_o}, 32'h155);
    check("R2 after release chroma", {22'd0, chroma_o}, 32'h266);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule